// File: doc/BRIEF.md
# Supply Fail Reset Sequencer

This block takes a single digital status bit that says whether the main supply sits above its write-protect threshold. It turns that bit into three control results: a write-protect flag, an active-low reset request, and a power-good status. When the supply drops out of tolerance, write protection and reset are both asserted after a short, fixed latency. The memory-control strobes that pass through the block are forced inactive while write protection is on. When the supply comes back, two independent hold timers start. Write protection is lifted when the shorter one runs out. The reset request is released when the longer one runs out.

The reset request drives an open-drain pin. An output enable pulls the pin low, and a released pin floats, so an external pull-up sets the high level. The supply status is asynchronous to the clock and passes through a synchronizer first. Every interval is a parameter given in clock cycles, so a chip build can use real millisecond counts while a simulation uses a few cycles. Any new supply failure during a hold interval reloads both timers and asserts both outputs again.

Below, S is `SYNC_STAGES`, W is `WP_HOLD_CYC` and T is `RST_HOLD_CYC`. "Edge k" means the k-th rising clock edge after `supplyOk` changes between edges.

Top module: `supply_fail_seq`

## Requirements
- R1: While `rstN` is low, and after it is released with `supplyOk` low, `wrProt`=1, `rstOe`=1, `rstPinN`=0, `pwrGood`=0, and `memCeN`/`memWeN`/`memOeN` are all 1.
- R2: When `supplyOk` falls while the block is powered, the outputs still show the powered state (`wrProt`=0, `rstOe`=0, `pwrGood`=1) after edge S. After edge S+1, `wrProt`=1, `rstOe`=1 and `pwrGood`=0.
- R3: When `supplyOk` rises after being low for at least S+1 edges and then stays high, `wrProt` stays 1 through edge S+W and becomes 0 at edge S+W+1.
- R4: Under the same conditions, `rstOe` stays 1 through edge S+T and becomes 0 at edge S+T+1. T is greater than W, so reset is never released while write protection is on.
- R5: `pwrGood` is a registered output. It is 1 only from the edge at which reset is released, and only while the supply stays valid.
- R6: `rstPinN` is 0 when `rstOe`=1 and high impedance when `rstOe`=0. It never drives 1.
- R7: While `wrProt`=1, `memCeN`, `memWeN` and `memOeN` are held at 1 whatever `hostCeN`, `hostWeN` and `hostOeN` are. While `wrProt`=0, each one equals its host input without delay.
- R8: A supply drop of any length during either hold interval, including a single cycle, restarts both timers. It re-asserts any output that had already been released. Release timing then follows R3 and R4, counted from the edge where the supply came back.
- R9: If the synchronized supply drop reaches the edge at which write protection would have been released, `wrProt` does not fall, not even for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| supplyOk | input | 1 | Supply-in-tolerance status, asynchronous |
| hostCeN | input | 1 | Chip enable from the host, active low |
| hostWeN | input | 1 | Write enable from the host, active low |
| hostOeN | input | 1 | Output enable from the host, active low |
| memCeN | output | 1 | Gated chip enable to the memory |
| memWeN | output | 1 | Gated write enable to the memory |
| memOeN | output | 1 | Gated output enable to the memory |
| wrProt | output | 1 | Write protection active |
| rstOe | output | 1 | Open-drain enable for the reset pin (1 pulls low) |
| rstPinN | output | 1 | Modelled open-drain reset pin: 0 or high impedance |
| pwrGood | output | 1 | Registered: supply valid and both hold timers done |

## Verification
Two events can fall in the same cycle: the write-protect timer running out, and a newly synchronized supply drop. Had the release won that cycle, protection would lift for one cycle just as the supply is failing. The bench powers up and counts edges so that a one-cycle low pulse on `supplyOk` leaves the synchronizer exactly at the release edge, edge S+W. It samples `wrProt` after every edge and requires it to stay 1 throughout. A fresh release must then follow at the normal distance from the edge where the supply returned. A longer drop placed inside the reset-only interval checks the other overlap: protection that was already released is re-asserted while reset is still held.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

  localparam int NUM_TMR = 2;
  localparam int TMR_WP  = 0;
  localparam int TMR_RST = 1;

  // Control to datapath strobes.
  typedef struct packed {
    logic reload;   // restart every hold timer
    logic tick;     // advance every running hold timer
  } seqStrobe_t;

  // Datapath to control status.
  typedef struct packed {
    logic               supOk;  // synchronized supply status
    logic [NUM_TMR-1:0] done;   // per-timer expiry
  } seqStatus_t;

endpackage

// File: rtl/sfs_dp.sv
module sfs_dp
  import sfs_pkg::*;
#(
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned WP_HOLD_CYC  = 12_500_000,
  parameter int unsigned RST_HOLD_CYC = 20_000_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyOk,
  input  seqStrobe_t strobe,
  input  logic       wrProt,
  input  logic       hostCeN,
  input  logic       hostWeN,
  input  logic       hostOeN,
  output seqStatus_t status,
  output logic       memCeN,
  output logic       memWeN,
  output logic       memOeN
);

  localparam int CNT_W = $clog2(RST_HOLD_CYC + 1);

  // Synchronizer chain for the asynchronous supply status.
  logic [SYNC_STAGES-1:0] syncQ;

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          syncQ[s] <= 1'b0;
        end else if (s == 0) begin
          syncQ[s] <= supplyOk;
        end else begin
          syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign status.supOk = syncQ[SYNC_STAGES-1];

  // Hold timers: load on reload, count down to zero on tick.
  genvar g;
  generate
    for (g = 0; g < NUM_TMR; g++) begin : g_tmr
      localparam logic [CNT_W-1:0] HOLD_V =
        (g == TMR_WP) ? CNT_W'(WP_HOLD_CYC) : CNT_W'(RST_HOLD_CYC);

      logic [CNT_W-1:0] cntQ;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          cntQ <= HOLD_V;
        end else if (strobe.reload) begin
          cntQ <= HOLD_V;
        end else if (strobe.tick && (cntQ != '0)) begin
          cntQ <= cntQ - CNT_W'(1);
        end
      end

      assign status.done[g] = (cntQ == '0);

      AST_TIMER_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
        strobe.reload |=> (cntQ == HOLD_V)); // R8
    end
  endgenerate

  // Memory-control gating: forced inactive under write protection.
  always_comb begin
    memCeN = hostCeN | wrProt;
    memWeN = hostWeN | wrProt;
    memOeN = hostOeN | wrProt;
  end

endmodule

// File: rtl/sfs_ctrl.sv
module sfs_ctrl
  import sfs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  seqStatus_t status,
  output seqStrobe_t strobe,
  output logic       wrProt,
  output logic       rstOe,
  output logic       pwrGood
);

  logic wpRelease;
  logic rstRelease;

  always_comb begin
    strobe.reload = !status.supOk;
    strobe.tick   = status.supOk;
    wpRelease     = status.supOk && status.done[TMR_WP];
    rstRelease    = status.supOk && status.done[TMR_RST];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrProt  <= 1'b1;
      rstOe   <= 1'b1;
      pwrGood <= 1'b0;
    end else begin
      wrProt  <= !wpRelease;
      rstOe   <= !rstRelease;
      pwrGood <= wpRelease && rstRelease;
    end
  end

  AST_FAIL_PROTECT: assert property (@(posedge clk) disable iff (!rstN)
    !status.supOk |=> (wrProt && rstOe && !pwrGood)); // R2

  AST_WP_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wrProt) |-> $past(status.done[TMR_WP]) && $past(status.supOk)); // R3

  AST_RST_AFTER_WP: assert property (@(posedge clk) disable iff (!rstN)
    !rstOe |-> !wrProt); // R4

  AST_PG_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    pwrGood |-> (!rstOe && !wrProt && $past(status.supOk))); // R5

endmodule

// File: rtl/supply_fail_seq.sv
module supply_fail_seq
  import sfs_pkg::*;
#(
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned WP_HOLD_CYC  = 12_500_000,
  parameter int unsigned RST_HOLD_CYC = 20_000_000
) (
  input  logic clk,
  input  logic rstN,
  input  logic supplyOk,
  input  logic hostCeN,
  input  logic hostWeN,
  input  logic hostOeN,
  output logic memCeN,
  output logic memWeN,
  output logic memOeN,
  output logic wrProt,
  output logic rstOe,
  output wire  rstPinN,
  output logic pwrGood
);

  seqStrobe_t strobe;
  seqStatus_t status;

  sfs_dp #(
    .SYNC_STAGES (SYNC_STAGES),
    .WP_HOLD_CYC (WP_HOLD_CYC),
    .RST_HOLD_CYC(RST_HOLD_CYC)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .supplyOk(supplyOk),
    .strobe  (strobe),
    .wrProt  (wrProt),
    .hostCeN (hostCeN),
    .hostWeN (hostWeN),
    .hostOeN (hostOeN),
    .status  (status),
    .memCeN  (memCeN),
    .memWeN  (memWeN),
    .memOeN  (memOeN)
  );

  sfs_ctrl i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .status (status),
    .strobe (strobe),
    .wrProt (wrProt),
    .rstOe  (rstOe),
    .pwrGood(pwrGood)
  );

  // Open-drain pin: pulls low or floats, never drives high.
  assign rstPinN = rstOe ? 1'b0 : 1'bz;

  AST_GATE_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    wrProt |-> (memCeN && memWeN && memOeN)); // R7

endmodule

// File: tb/test_supply_fail_seq.sv
`timescale 1ns/1ps
module test_supply_fail_seq;

  localparam int S  = 2;
  localparam int WP = 10;
  localparam int RT = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyOk = 1'b0;
  logic hostCeN = 1'b1, hostWeN = 1'b1, hostOeN = 1'b1;
  logic memCeN, memWeN, memOeN, wrProt, rstOe, pwrGood;
  wire  rstPinN;

  int nCmp = 0;
  int nErr = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  supply_fail_seq #(
    .SYNC_STAGES(S), .WP_HOLD_CYC(WP), .RST_HOLD_CYC(RT)
  ) i_supply_fail_seq (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk),
    .hostCeN(hostCeN), .hostWeN(hostWeN), .hostOeN(hostOeN),
    .memCeN(memCeN), .memWeN(memWeN), .memOeN(memOeN),
    .wrProt(wrProt), .rstOe(rstOe), .rstPinN(rstPinN), .pwrGood(pwrGood)
  );

  task automatic check(input string req, input logic act, input logic exp);
    nCmp++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic setSupply(input logic v);
    @(negedge clk);
    supplyOk = v;
  endtask

  // Called right after the supply was driven valid at a negedge.
  task automatic checkPowerUp(input string tag);
    for (int k = 1; k <= S + RT + 1; k++) begin
      logic expWp, expRst;
      @(posedge clk);
      #1;
      expWp  = (k < S + WP + 1);
      expRst = (k < S + RT + 1);
      check({tag, " R3 wrProt"}, wrProt, expWp);
      check({tag, " R4 rstOe"}, rstOe, expRst);
      check({tag, " R5 pwrGood"}, pwrGood, !expRst);
      check({tag, " R6 rstPinN"}, rstPinN, expRst ? 1'b0 : 1'bz);
    end
  endtask

  task automatic checkAsserted(input string tag);
    check({tag, " wrProt"}, wrProt, 1'b1);
    check({tag, " rstOe"}, rstOe, 1'b1);
    check({tag, " pwrGood"}, pwrGood, 1'b0);
  endtask

  task automatic tReset();
    waitEdges(2);
    checkAsserted("R1 in reset");
    check("R1 pin in reset", rstPinN, 1'b0);
    check("R1 memCeN", memCeN, 1'b1);
    check("R1 memWeN", memWeN, 1'b1);
    check("R1 memOeN", memOeN, 1'b1);
    @(negedge clk);
    rstN = 1'b1;
    waitEdges(6);
    checkAsserted("R1 after reset, supply low");
    check("R1 pin after reset", rstPinN, 1'b0);
  endtask

  task automatic tPowerUp();
    setSupply(1'b1);
    checkPowerUp("R3/R4 plain");
  endtask

  task automatic tGate();
    logic [2:0] pats [4] = '{3'b010, 3'b101, 3'b000, 3'b110};
    foreach (pats[i]) begin
      @(negedge clk);
      {hostCeN, hostWeN, hostOeN} = pats[i];
      #1;
      check("R7 pass ce", memCeN, pats[i][2]);
      check("R7 pass we", memWeN, pats[i][1]);
      check("R7 pass oe", memOeN, pats[i][0]);
    end
  endtask

  task automatic tFail();
    setSupply(1'b0);
    waitEdges(S);
    check("R2 before bound wrProt", wrProt, 1'b0);
    check("R2 before bound rstOe", rstOe, 1'b0);
    check("R2 before bound pwrGood", pwrGood, 1'b1);
    waitEdges(1);
    checkAsserted("R2 at bound");
    @(negedge clk);
    {hostCeN, hostWeN, hostOeN} = 3'b000;
    #1;
    check("R7 block ce", memCeN, 1'b1);
    check("R7 block we", memWeN, 1'b1);
    check("R7 block oe", memOeN, 1'b1);
    {hostCeN, hostWeN, hostOeN} = 3'b111;
    setSupply(1'b1);
    checkPowerUp("R2 recovery");
  endtask

  task automatic tGlitchWp();
    setSupply(1'b0);
    waitEdges(S + 1);
    setSupply(1'b1);
    waitEdges(S + 3);
    check("R8 mid wp hold", wrProt, 1'b1);
    setSupply(1'b0);
    setSupply(1'b1);
    checkPowerUp("R8 wp glitch");
  endtask

  task automatic tGlitchRst();
    setSupply(1'b0);
    waitEdges(S + 1);
    setSupply(1'b1);
    waitEdges(S + WP + 3);
    check("R8 in rst hold wrProt", wrProt, 1'b0);
    check("R8 in rst hold rstOe", rstOe, 1'b1);
    setSupply(1'b0);
    waitEdges(S + 1);
    checkAsserted("R8 reasserted");
    setSupply(1'b1);
    checkPowerUp("R8 rst glitch");
  endtask

  task automatic tSameCycle();
    setSupply(1'b0);
    waitEdges(S + 1);
    setSupply(1'b1);
    for (int k = 1; k <= S + WP - 2; k++) begin
      waitEdges(1);
      check("R9 before glitch", wrProt, 1'b1);
    end
    setSupply(1'b0);
    waitEdges(1);
    check("R9 glitch edge", wrProt, 1'b1);
    setSupply(1'b1);
    checkPowerUp("R9 collision");
  endtask

  initial begin
    tReset();
    tPowerUp();
    tGate();
    tFail();
    tGlitchWp();
    tGlitchRst();
    tSameCycle();
    waitEdges(2);
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nErr);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1'b1;
      nCmp++;
      nErr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nErr);
      $finish;
    end
  end

endmodule